// File: doc/BRIEF.md
# Paired Return Address Stack with Associative Search

This block is a hardware stack of call records. Each record pairs the entry address of a called function (the call target) with the return address (the instruction after the call site). Each record also carries two flags. A means that deeper records share the same entry address. R means the record stands for a direct recursion that is reused. Calls push records, and a push may arrive before the call commits. Records leave the stack only when a function return commits.

A committed return presents the function entry address and the return address read from the program stack. It also gives a mode bit. The block scans every valid record from the top down and takes the first one that qualifies. On a hit it redirects fetch to the stored return address and pops the records above the hit. The hit record is popped too unless its R flag is set. For every popped record whose A flag is clear, its entry address is offered one per cycle to a companion table, which clears its outstanding marks. When nothing qualifies, the block raises an alarm and leaves the stack as it was.

Top module: `ret_pair_stack`

## Requirements
- R1: After reset the stack is empty: `level` is 0, `ret_busy`, `rel_valid`, `redirect_valid`, `alarm` and `push_overflow` are all 0.
- R2: An accepted push whose pair differs from the top record stores (`push_entry`, `push_ret`) as the new top record. Its A flag equals `push_dup` and its R flag is clear. `level` rises by one on the accepting edge.
- R3: An accepted push whose entry address and return address both equal those of the top record adds no record. It sets that record's R flag instead, and `level` is unchanged.
- R4: An accepted push onto a stack holding DEPTH records discards the bottom record and stores the new one on top. `level` stays at DEPTH and `push_overflow` is high for exactly the one cycle after the accepting edge.
- R5: With `ret_mode`=0 the search takes the topmost record whose entry address equals `ret_entry`. If that record has A set, the search takes the topmost record whose entry address equals `ret_entry` and whose return address equals `ret_addr`. If no such record exists, the search misses.
- R6: With `ret_mode`=1 the search takes the topmost record whose entry address and return address both match the inputs.
- R7: A return is accepted when `ret_valid` is high and `ret_busy` is low. On a hit, `redirect_valid` is high for the one cycle after the accepting edge, and `redirect_addr` then holds the matched record's return address.
- R8: On a hit, every record above the matched one is popped. The matched record is popped as well when its R flag is clear, and it is kept when its R flag is set.
- R9: Pops happen from the top, at most one per cycle. A popped record with A clear is offered on `rel_entry` with `rel_valid` and is removed only on a cycle where `rel_ready` is high. A record with A set is removed without being offered. `ret_busy` stays high until the last pop.
- R10: On a miss, `alarm` is high for the one cycle after the accepting edge, `redirect_valid` stays low, and the stack is unchanged.
- R11: A push is ignored while `ret_busy` is high, and it is ignored when it arrives in the same cycle as `ret_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push a call record |
| push_entry | input | AW | Called function entry address |
| push_ret | input | AW | Return address of the call |
| push_dup | input | 1 | Value written into the A flag |
| push_overflow | output | 1 | One-cycle pulse: bottom record discarded |
| ret_valid | input | 1 | Committed return request |
| ret_mode | input | 1 | 0: match on entry address, 1: match on both addresses |
| ret_entry | input | AW | Entry address of the returning function |
| ret_addr | input | AW | Return address read from the program stack |
| ret_busy | output | 1 | Pops in progress; requests are not taken |
| redirect_valid | output | 1 | One-cycle pulse: fetch redirect |
| redirect_addr | output | AW | Redirect target |
| alarm | output | 1 | One-cycle pulse: return found no record |
| rel_valid | output | 1 | Popped entry address offered |
| rel_entry | output | AW | Entry address of the popped record |
| rel_ready | input | 1 | Companion table takes the offered address |
| level | output | $clog2(DEPTH+1) | Number of valid records |

## Verification
Random traffic draws entry and return addresses from small pools. This makes top-of-stack duplicates, repeated entry addresses at several depths and records with A set common, so the bench compares the topmost-entry search against the confirm-by-both search on the same stacks. Return queries also use addresses outside the pools, so hits and misses are both checked. `rel_ready` toggles at random, which shows whether a pop waits for the handshake only when A is clear. Directed cases cover an empty-stack return, fold-in of recursion and reuse of the kept record, overflow past DEPTH, and pushes offered while the block is busy.

// File: rtl/ret_pair_stack.sv
module ret_pair_stack #(
  parameter int DEPTH = 16,
  parameter int AW    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_valid,
  input  logic [AW-1:0]              push_entry,
  input  logic [AW-1:0]              push_ret,
  input  logic                       push_dup,
  output logic                       push_overflow,
  input  logic                       ret_valid,
  input  logic                       ret_mode,
  input  logic [AW-1:0]              ret_entry,
  input  logic [AW-1:0]              ret_addr,
  output logic                       ret_busy,
  output logic                       redirect_valid,
  output logic [AW-1:0]              redirect_addr,
  output logic                       alarm,
  output logic                       rel_valid,
  output logic [AW-1:0]              rel_entry,
  input  logic                       rel_ready,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int IW = $clog2(DEPTH);

  logic [AW-1:0]    ent [DEPTH];
  logic [AW-1:0]    ra  [DEPTH];
  logic [DEPTH-1:0] af, rf;
  logic             draining;
  logic [CW-1:0]    target;

  logic [IW-1:0] tidx;
  logic          full, dup, push_go, ret_go, pop_now;
  logic          fe_found, fb_found, hit, keep;
  logic [IW-1:0] fe_idx, fb_idx, hidx;

  assign tidx     = IW'(level - CW'(1));
  assign full     = (level == CW'(DEPTH));
  assign ret_busy = draining;
  assign ret_go   = ret_valid && !draining;
  assign push_go  = push_valid && !draining && !ret_valid;
  assign dup      = (level != '0) && ent[tidx] == push_entry && ra[tidx] == push_ret;

  always_comb begin
    fe_found = 1'b0;
    fb_found = 1'b0;
    fe_idx   = '0;
    fb_idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < level && ent[i] == ret_entry) begin
        fe_found = 1'b1;
        fe_idx   = IW'(i);
        if (ra[i] == ret_addr) begin
          fb_found = 1'b1;
          fb_idx   = IW'(i);
        end
      end
    end
  end

  assign hit  = ret_mode ? fb_found : (fe_found && (!af[fe_idx] || fb_found));
  assign hidx = (ret_mode || af[fe_idx]) ? fb_idx : fe_idx;
  assign keep = rf[hidx];

  assign rel_valid = draining && !af[tidx];
  assign rel_entry = ent[tidx];
  assign pop_now   = draining && (af[tidx] || rel_ready);

  always_ff @(posedge clk) begin
    if (push_go && !dup) begin
      if (full) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          ent[i] <= ent[i+1];
          ra[i]  <= ra[i+1];
        end
        ent[DEPTH-1] <= push_entry;
        ra[DEPTH-1]  <= push_ret;
      end else begin
        ent[IW'(level)] <= push_entry;
        ra[IW'(level)]  <= push_ret;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level          <= '0;
      af             <= '0;
      rf             <= '0;
      draining       <= 1'b0;
      target         <= '0;
      push_overflow  <= 1'b0;
      redirect_valid <= 1'b0;
      redirect_addr  <= '0;
      alarm          <= 1'b0;
    end else begin
      push_overflow  <= 1'b0;
      redirect_valid <= 1'b0;
      alarm          <= 1'b0;
      if (ret_go) begin
        if (hit) begin
          redirect_valid <= 1'b1;
          redirect_addr  <= ra[hidx];
          target         <= CW'(hidx) + (keep ? CW'(1) : CW'(0));
          draining       <= (CW'(hidx) + (keep ? CW'(1) : CW'(0))) != level;
        end else begin
          alarm <= 1'b1;
        end
      end else if (push_go) begin
        if (dup) begin
          rf[tidx] <= 1'b1;
        end else if (full) begin
          af            <= {push_dup, af[DEPTH-1:1]};
          rf            <= {1'b0, rf[DEPTH-1:1]};
          push_overflow <= 1'b1;
        end else begin
          af[IW'(level)] <= push_dup;
          rf[IW'(level)] <= 1'b0;
          level          <= level + CW'(1);
        end
      end else if (pop_now) begin
        level <= level - CW'(1);
        if (level - CW'(1) == target) draining <= 1'b0;
      end
    end
  end
endmodule

module ret_pair_stack_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       push_overflow,
  input logic                       ret_busy,
  input logic                       redirect_valid,
  input logic                       alarm,
  input logic                       rel_valid,
  input logic [AW-1:0]              rel_entry,
  input logic                       rel_ready,
  input logic [$clog2(DEPTH+1)-1:0] level
);
  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ($clog2(DEPTH+1))'(DEPTH));
  // R4
  overflow_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_overflow |-> level == ($clog2(DEPTH+1))'(DEPTH));
  // R9
  rel_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> ret_busy);
  // R9
  rel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid && !rel_ready |=> rel_valid && $stable(rel_entry));
  // R11
  busy_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_busy |=> level <= $past(level));
  // R10
  alarm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> !redirect_valid && !ret_busy);
  // R10
  alarm_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> level == $past(level));
endmodule

bind ret_pair_stack ret_pair_stack_chk #(.DEPTH(DEPTH), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .push_overflow(push_overflow), .ret_busy(ret_busy),
  .redirect_valid(redirect_valid), .alarm(alarm), .rel_valid(rel_valid),
  .rel_entry(rel_entry), .rel_ready(rel_ready), .level(level)
);

// File: tb/test_ret_pair_stack.sv
module test_ret_pair_stack;
  localparam int DEPTH = 16;
  localparam int AW    = 32;
  localparam int CW    = $clog2(DEPTH+1);

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, push_dup = 0, ret_valid = 0, ret_mode = 0, rel_ready = 0;
  logic [AW-1:0] push_entry = 0, push_ret = 0, ret_entry = 0, ret_addr = 0;
  logic push_overflow, ret_busy, redirect_valid, alarm, rel_valid;
  logic [AW-1:0] redirect_addr, rel_entry;
  logic [CW-1:0] level;

  always #4 clk = ~clk;

  ret_pair_stack #(.DEPTH(DEPTH), .AW(AW)) i_ret_pair_stack (.*);

  int checks = 0, failures = 0;
  logic [AW-1:0] m_e [DEPTH];
  logic [AW-1:0] m_r [DEPTH];
  bit m_a [DEPTH];
  bit m_rr [DEPTH];
  int mcnt = 0;

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int find(input logic [AW-1:0] e, input logic [AW-1:0] r, input bit mode);
    int first_e = -1, first_b = -1;
    for (int k = mcnt - 1; k >= 0; k--) begin
      if (m_e[k] == e && first_e < 0) first_e = k;
      if (m_e[k] == e && m_r[k] == r && first_b < 0) first_b = k;
    end
    if (mode || (first_e >= 0 && m_a[first_e])) return first_b;
    return first_e;
  endfunction

  task automatic do_push(input logic [AW-1:0] e, input logic [AW-1:0] r, input bit a);
    bit isdup, ovf;
    isdup = mcnt > 0 && m_e[mcnt-1] == e && m_r[mcnt-1] == r;
    ovf = !isdup && mcnt == DEPTH;
    push_valid = 1; push_entry = e; push_ret = r; push_dup = a;
    @(posedge clk); @(negedge clk);
    push_valid = 0;
    if (isdup) m_rr[mcnt-1] = 1;
    else begin
      if (ovf) begin
        for (int k = 0; k < DEPTH - 1; k++) begin
          m_e[k] = m_e[k+1]; m_r[k] = m_r[k+1]; m_a[k] = m_a[k+1]; m_rr[k] = m_rr[k+1];
        end
        mcnt = DEPTH - 1;
      end
      m_e[mcnt] = e; m_r[mcnt] = r; m_a[mcnt] = a; m_rr[mcnt] = 0; mcnt++;
    end
    chk(level == CW'(mcnt), isdup ? "R3 level" : "R2 level", AW'(level), AW'(mcnt));
    chk(push_overflow == ovf, "R4 overflow pulse", AW'(push_overflow), AW'(ovf));
  endtask

  task automatic do_ret(input logic [AW-1:0] e, input logic [AW-1:0] r, input bit mode, input bit spam);
    int h, tgt, n, got;
    logic [AW-1:0] exp_rel [DEPTH];
    h = find(e, r, mode);
    ret_valid = 1; ret_entry = e; ret_addr = r; ret_mode = mode;
    if (spam) begin push_valid = 1; push_entry = 32'hDEAD; push_ret = 32'hBEEF; push_dup = 0; end
    @(posedge clk); @(negedge clk);
    ret_valid = 0;
    chk(redirect_valid == (h >= 0), mode ? "R6 hit" : "R5 hit", AW'(redirect_valid), AW'(h >= 0));
    chk(alarm == (h < 0), "R10 alarm", AW'(alarm), AW'(h < 0));
    if (h >= 0) chk(redirect_addr == m_r[h], "R7 redirect addr", redirect_addr, m_r[h]);
    n = 0;
    tgt = (h < 0) ? mcnt : (m_rr[h] ? h + 1 : h);
    for (int k = mcnt - 1; k >= tgt; k--) if (!m_a[k]) begin exp_rel[n] = m_e[k]; n++; end
    got = 0;
    for (int it = 0; it < 200 && ret_busy; it++) begin
      rel_ready = $urandom % 2;
      if (rel_valid && rel_ready) begin
        if (got < n) chk(rel_entry == exp_rel[got], "R9 release order", rel_entry, exp_rel[got]);
        got++;
      end
      @(posedge clk); @(negedge clk);
    end
    push_valid = 0; rel_ready = 0;
    chk(got == n, "R9 release count", AW'(got), AW'(n));
    chk(!ret_busy, "R9 busy ends", AW'(ret_busy), 0);
    mcnt = tgt;
    chk(level == CW'(mcnt), spam ? "R11 push ignored" : "R8 level after pop", AW'(level), AW'(mcnt));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R9 actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk(level == 0 && !ret_busy && !rel_valid && !redirect_valid && !alarm && !push_overflow,
        "R1 reset state", AW'(level), 0);
    do_ret(32'h700, 32'h110, 0, 0);                 // R10 empty stack
    do_push(32'h700, 32'h110, 0);                   // R2
    do_push(32'h700, 32'h150, 1);
    do_push(32'h700, 32'h150, 1);                   // R3 folds into top
    do_ret(32'h700, 32'h150, 0, 0);                 // R5 A set -> confirm, R8 kept
    do_ret(32'h700, 32'h150, 1, 0);                 // R6 reuse
    do_ret(32'h700, 32'h999, 1, 0);                 // R10 miss
    do_push(32'h900, 32'h210, 0);
    do_ret(32'h700, 32'h110, 0, 1);                 // R11 push during request and drain
    for (int i = 0; i < DEPTH + 2; i++) do_push(32'h1000 + i, 32'h2000 + i, i % 3 == 0); // R4
    do_ret(32'h1003, 32'h2003, 0, 1);               // R8 deep pop, R11
    for (int i = 0; i < 500; i++) begin
      logic [AW-1:0] e, r;
      e = 32'h100 * (1 + $urandom % 4);
      r = 32'h10 * (1 + $urandom % 3);
      if ($urandom % 3 != 0) do_push(e, r, $urandom % 2);
      else begin
        if ($urandom % 8 == 0) e = 32'h5555;
        do_ret(e, r, $urandom % 2, $urandom % 4 == 0);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule